// File: doc/BRIEF.md
# Block-Sweep Memory Self-Test Engine

This engine tests a byte-addressed memory through a controller that moves data in fixed-length bursts. On start it walks the address space in 1024-byte blocks. Each block is first filled with a counting byte pattern and then read back in full, and every byte is compared against the value that was written. Mismatches are counted, and the first one is captured with its address, the expected byte and the byte actually read. After the last block the sweep is complete. The engine runs as many sweeps as were requested at start and then raises done.

The pattern depends only on a byte's offset inside its block, so every block receives the same data. An integration flow drives `sweep_cnt` and pulses `start`. It then waits for `done` and reads the error total, the sweep count and the failure capture. The memory controller is a separate block. The engine only issues burst requests and exchanges one byte per accepted beat.

Top module: `blk_sweep_bist`

## Requirements
- R1: After reset `busy`, `done` and `fail_valid` are low, and `err_count` and `pass_count` are zero.
- R2: A `start` pulse while idle makes `busy` high in the next cycle. A `start` while busy is ignored: the sweep count latched at the first start stays in force and the counts are not cleared.
- R3: Memory is visited block by block from address 0 upward. Each 1024-byte block is written with ascending bursts, and only then is it read back with the same ascending bursts, before the next block begins. Every burst address is a multiple of 8, and `mem_len` is 8.
- R4: The byte written to address a is (a mod 1024) mod 256, which is a[7:0].
- R5: Each byte read back that differs from its pattern value adds one to `err_count`. The count saturates at 2^ERR_W-1.
- R6: The first mismatch after a start sets `fail_valid`, and `fail_addr`, `fail_exp` and `fail_act` hold its address, expected byte and read byte. Later mismatches do not change them.
- R7: `pass_count` rises by one after each complete sweep. The engine runs `sweep_cnt` sweeps, with 0 treated as 1, and then drops `busy` and raises `done`.
- R8: An accepted `start` clears `err_count`, `pass_count`, `done` and the failure capture.
- R9: `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_gnt`. Data moves only on cycles with `mem_wready` (write) or `mem_rvalid` (read), so the controller may stall between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (one-cycle pulse) |
| sweep_cnt | input | PASS_W | Number of full sweeps to run, 0 means 1 |
| busy | output | 1 | Test in progress |
| done | output | 1 | Last run finished, held until the next start |
| err_count | output | ERR_W | Saturating mismatch count |
| pass_count | output | PASS_W | Completed sweeps in this run |
| fail_valid | output | 1 | A mismatch has been captured |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_exp | output | 8 | Expected byte at first mismatch |
| fail_act | output | 8 | Byte read at first mismatch |
| mem_req | output | 1 | Burst request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Burst start address (also current byte address) |
| mem_len | output | LEN_W | Burst length in bytes |
| mem_gnt | input | 1 | Request accepted |
| mem_wdata | output | 8 | Write byte for the current beat |
| mem_wready | input | 1 | Controller takes `mem_wdata` this cycle |
| mem_rdata | input | 8 | Read byte |
| mem_rvalid | input | 1 | `mem_rdata` valid this cycle |

## Verification
The bench injects read-side bit flips and goes after several corner cases. It places two faults in different blocks and runs three sweeps. A capture that was not frozen would report the later address, and a counter that was cleared between sweeps would show 2 instead of 6. It floods the memory with faults to reach the counter ceiling, where a counter without saturation would wrap to a small value. It stalls the controller between beats and before grants, which exposes a design that advances its offset without a beat or drops its request early. It also sends a second start with a different sweep count in the middle of a run, asks for zero sweeps, and restarts after a failing run. A design that reloaded the count, ran no sweep at all, or kept stale failure data would be caught.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_WDAT,
    ST_RREQ,
    ST_RDAT
  } sweep_st_e;
endpackage

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_pkg::*;
#(
  parameter int MEM_BYTES   = 32768,
  parameter int BLOCK_BYTES = 1024,
  parameter int BURST_BYTES = 8,
  parameter int PASS_W      = 8,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BEAT_W     = $clog2(BURST_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PASS_W-1:0] sweep_cnt,
  output logic              busy,
  output logic              done,
  output logic [PASS_W-1:0] pass_count,
  output logic              clr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  output logic [7:0]        mem_wdata,
  input  logic              mem_wready,
  input  logic              mem_rvalid,
  output logic              cmp_en,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [7:0]        cmp_exp
);
  localparam logic [ADDR_W-1:0] LAST_BASE = ADDR_W'(MEM_BYTES - BLOCK_BYTES);
  localparam logic [ADDR_W-1:0] BLK_STEP  = ADDR_W'(BLOCK_BYTES);

  sweep_st_e         st_q, st_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [PASS_W-1:0] goal_q, goal_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic              done_q, done_d;

  logic [ADDR_W-1:0] byte_addr;
  logic              beat_last, blk_last, mem_last;
  logic [PASS_W-1:0] pass_inc;

  assign byte_addr = base_q + ADDR_W'(off_q);
  assign beat_last = &off_q[BEAT_W-1:0];
  assign blk_last  = &off_q;
  assign mem_last  = (base_q == LAST_BASE);
  assign pass_inc  = pass_q + PASS_W'(1);

  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    base_d = base_q;
    goal_d = goal_q;
    pass_d = pass_q;
    done_d = done_q;
    clr    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          clr    = 1'b1;
          done_d = 1'b0;
          pass_d = '0;
          base_d = '0;
          off_d  = '0;
          goal_d = (sweep_cnt == '0) ? PASS_W'(1) : sweep_cnt;
          st_d   = ST_WREQ;
        end
      end
      ST_WREQ: if (mem_gnt) st_d = ST_WDAT;
      ST_WDAT: begin
        if (mem_wready) begin
          off_d = off_q + OFF_W'(1);
          if (beat_last) st_d = blk_last ? ST_RREQ : ST_WREQ;
        end
      end
      ST_RREQ: if (mem_gnt) st_d = ST_RDAT;
      ST_RDAT: begin
        if (mem_rvalid) begin
          off_d = off_q + OFF_W'(1);
          if (beat_last) begin
            if (!blk_last) begin
              st_d = ST_RREQ;
            end else if (!mem_last) begin
              base_d = base_q + BLK_STEP;
              st_d   = ST_WREQ;
            end else begin
              base_d = '0;
              pass_d = pass_inc;
              if (pass_inc == goal_q) begin
                done_d = 1'b1;
                st_d   = ST_IDLE;
              end else begin
                st_d = ST_WREQ;
              end
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      off_q  <= '0;
      base_q <= '0;
      goal_q <= '0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      base_q <= base_d;
      goal_q <= goal_d;
      pass_q <= pass_d;
      done_q <= done_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign pass_count = pass_q;
  assign mem_req    = (st_q == ST_WREQ) || (st_q == ST_RREQ);
  assign mem_we     = (st_q == ST_WREQ);
  assign mem_addr   = byte_addr;
  assign mem_wdata  = 8'(off_q);
  assign cmp_en     = (st_q == ST_RDAT) && mem_rvalid;
  assign cmp_addr   = byte_addr;
  assign cmp_exp    = 8'(off_q);
endmodule

// File: rtl/sweep_chk.sv
module sweep_chk #(
  parameter int ADDR_W = 15,
  parameter int ERR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cmp_en,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [7:0]        cmp_exp,
  input  logic [7:0]        cmp_act,
  output logic [ERR_W-1:0]  err_count,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_act
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ERR_W-1:0]  err_q, err_d;
  logic              fv_q, fv_d;
  logic [ADDR_W-1:0] fa_q, fa_d;
  logic [7:0]        fe_q, fe_d, fx_q, fx_d;
  logic              miss;

  assign miss = cmp_en && (cmp_exp != cmp_act);

  always_comb begin
    err_d = err_q;
    fv_d  = fv_q;
    fa_d  = fa_q;
    fe_d  = fe_q;
    fx_d  = fx_q;
    if (clr) begin
      err_d = '0;
      fv_d  = 1'b0;
      fa_d  = '0;
      fe_d  = '0;
      fx_d  = '0;
    end else if (miss) begin
      if (err_q != ERR_MAX) err_d = err_q + ERR_W'(1);
      if (!fv_q) begin
        fv_d = 1'b1;
        fa_d = cmp_addr;
        fe_d = cmp_exp;
        fx_d = cmp_act;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      fv_q  <= 1'b0;
      fa_q  <= '0;
      fe_q  <= '0;
      fx_q  <= '0;
    end else begin
      err_q <= err_d;
      fv_q  <= fv_d;
      fa_q  <= fa_d;
      fe_q  <= fe_d;
      fx_q  <= fx_d;
    end
  end

  assign err_count  = err_q;
  assign fail_valid = fv_q;
  assign fail_addr  = fa_q;
  assign fail_exp   = fe_q;
  assign fail_act   = fx_q;
endmodule

// File: rtl/blk_sweep_bist.sv
module blk_sweep_bist #(
  parameter int MEM_BYTES   = 32768,
  parameter int BLOCK_BYTES = 1024,
  parameter int BURST_BYTES = 8,
  parameter int ERR_W       = 16,
  parameter int PASS_W      = 8,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int LEN_W      = $clog2(BURST_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PASS_W-1:0] sweep_cnt,
  output logic              busy,
  output logic              done,
  output logic [ERR_W-1:0]  err_count,
  output logic [PASS_W-1:0] pass_count,
  output logic              fail_valid,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_exp,
  output logic [7:0]        fail_act,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              mem_gnt,
  output logic [7:0]        mem_wdata,
  input  logic              mem_wready,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_rvalid
);
  logic              clr, cmp_en;
  logic [ADDR_W-1:0] cmp_addr;
  logic [7:0]        cmp_exp;

  assign mem_len = LEN_W'(BURST_BYTES);

  sweep_ctrl #(
    .MEM_BYTES(MEM_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .BURST_BYTES(BURST_BYTES), .PASS_W(PASS_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_cnt(sweep_cnt),
    .busy(busy), .done(done), .pass_count(pass_count), .clr(clr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .mem_rvalid(mem_rvalid), .cmp_en(cmp_en), .cmp_addr(cmp_addr),
    .cmp_exp(cmp_exp)
  );

  sweep_chk #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_en(cmp_en),
    .cmp_addr(cmp_addr), .cmp_exp(cmp_exp), .cmp_act(mem_rdata),
    .err_count(err_count), .fail_valid(fail_valid), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act)
  );
endmodule

// File: rtl/blk_sweep_bist_sva.sv
module blk_sweep_bist_sva #(
  parameter int ADDR_W      = 15,
  parameter int ERR_W       = 16,
  parameter int PASS_W      = 8,
  parameter int BURST_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ERR_W-1:0]  err_count,
  input logic [PASS_W-1:0] pass_count,
  input logic              fail_valid,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [7:0]        fail_exp,
  input logic [7:0]        fail_act,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R3
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr % ADDR_W'(BURST_BYTES)) == '0);

  // R5
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> err_count >= $past(err_count));

  // R6
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid && busy |=> fail_valid && $stable(fail_addr) &&
                           $stable(fail_exp) && $stable(fail_act));

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R7
  pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (pass_count == $past(pass_count)) ||
             (pass_count == $past(pass_count) + PASS_W'(1)));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done && !fail_valid &&
                       err_count == '0 && pass_count == '0);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind blk_sweep_bist blk_sweep_bist_sva #(
  .ADDR_W(ADDR_W), .ERR_W(ERR_W), .PASS_W(PASS_W), .BURST_BYTES(BURST_BYTES)
) i_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_count(err_count), .pass_count(pass_count), .fail_valid(fail_valid),
  .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt)
);

// File: tb/test_blk_sweep_bist.sv
module test_blk_sweep_bist;
  localparam int MEM   = 2048;
  localparam int BLK   = 1024;
  localparam int BURST = 8;
  localparam int EW    = 4;
  localparam int PW    = 4;
  localparam int AW    = $clog2(MEM);
  localparam int LW    = $clog2(BURST) + 1;

  logic clk, rst_n, start;
  logic [PW-1:0] sweep_cnt;
  logic busy, done, fail_valid;
  logic [EW-1:0] err_count;
  logic [PW-1:0] pass_count;
  logic [AW-1:0] fail_addr, mem_addr;
  logic [7:0] fail_exp, fail_act, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_gnt, mem_wready, mem_rvalid;
  logic [LW-1:0] mem_len;

  blk_sweep_bist #(.MEM_BYTES(MEM), .BLOCK_BYTES(BLK), .BURST_BYTES(BURST),
                   .ERR_W(EW), .PASS_W(PW)) i_blk_sweep_bist (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_cnt(sweep_cnt),
    .busy(busy), .done(done), .err_count(err_count), .pass_count(pass_count),
    .fail_valid(fail_valid), .fail_addr(fail_addr), .fail_exp(fail_exp),
    .fail_act(fail_act), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .mem_wdata(mem_wdata), .mem_wready(mem_wready), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] mem_arr [0:MEM-1];

  // fault model applied on reads
  int fmode = 0;
  logic [AW-1:0] f_a1, f_a2;
  logic [7:0] f_m1, f_m2;
  bit stall_en = 0;

  // expected request sequence
  int seq_bad = 0, seq_idx = 0, seq_base = 0;
  bit seq_we = 1;

  function automatic logic [7:0] flip(input logic [AW-1:0] a);
    logic [7:0] m = 8'h00;
    if (fmode == 1 || fmode == 2) if (a == f_a1) m = m | f_m1;
    if (fmode == 2) if (a == f_a2) m = m | f_m2;
    if (fmode == 3) if (a[3:0] == 4'h5) m = 8'h01;
    return m;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic seq_reset();
    seq_bad = 0; seq_idx = 0; seq_base = 0; seq_we = 1;
  endtask

  // memory controller model (R3 sequence tracking, R9 stalls)
  initial begin
    mem_gnt = 0; mem_wready = 0; mem_rvalid = 0; mem_rdata = 8'h00;
    for (int i = 0; i < MEM; i++) mem_arr[i] = 8'h00;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        logic [AW-1:0] a;
        logic w;
        a = mem_addr; w = mem_we;
        if (int'(a) != seq_base + seq_idx * BURST || w != seq_we ||
            int'(mem_len) != BURST) seq_bad++;
        seq_idx++;
        if (seq_idx == BLK / BURST) begin
          seq_idx = 0;
          if (seq_we) seq_we = 0;
          else begin
            seq_we = 1;
            seq_base = seq_base + BLK;
            if (seq_base == MEM) seq_base = 0;
          end
        end
        if (stall_en) @(negedge clk);
        mem_gnt = 1;
        @(negedge clk);
        mem_gnt = 0;
        for (int b = 0; b < BURST; b++) begin
          if (stall_en && b[0]) @(negedge clk);
          if (w) begin
            mem_wready = 1;
            mem_arr[int'(a) + b] = mem_wdata;
          end else begin
            mem_rvalid = 1;
            mem_rdata = mem_arr[int'(a) + b] ^ flip(a + AW'(b));
          end
          @(negedge clk);
          mem_wready = 0;
          mem_rvalid = 0;
        end
      end
    end
  end

  task automatic pulse_start(input logic [PW-1:0] cnt);
    sweep_cnt = cnt;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 60000) begin @(negedge clk); t++; end
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err_count", err_count, 0);
    chk("R1", "pass_count", pass_count, 0);
    chk("R1", "fail_valid", fail_valid, 0);
  endtask

  task automatic t_clean();
    int bad = 0;
    fmode = 0; seq_reset();
    pulse_start(4'd1);
    chk("R2", "busy after start", busy, 1);
    wait_done();
    chk("R7", "done", done, 1);
    chk("R7", "busy at end", busy, 0);
    chk("R7", "pass_count", pass_count, 1);
    chk("R5", "err_count clean", err_count, 0);
    chk("R6", "fail_valid clean", fail_valid, 0);
    chk("R3", "request order errors", seq_bad, 0);
    for (int i = 0; i < MEM; i++) if (mem_arr[i] !== 8'(i % BLK)) bad++;
    chk("R4", "pattern mismatches in memory", bad, 0);
  endtask

  task automatic t_single();
    fmode = 1; f_a1 = 11'h4A3; f_m1 = 8'h10; seq_reset();
    pulse_start(4'd1);
    wait_done();
    chk("R5", "err_count single", err_count, 1);
    chk("R6", "fail_valid", fail_valid, 1);
    chk("R6", "fail_addr", fail_addr, 32'h4A3);
    chk("R6", "fail_exp", fail_exp, 8'hA3);
    chk("R6", "fail_act", fail_act, 8'hB3);
  endtask

  task automatic t_multi();
    fmode = 2; f_a1 = 11'h7F0; f_m1 = 8'h80; f_a2 = 11'h105; f_m2 = 8'h01;
    seq_reset();
    pulse_start(4'd3);
    wait_done();
    chk("R7", "pass_count three sweeps", pass_count, 3);
    chk("R5", "err_count accumulates", err_count, 6);
    chk("R6", "first fail_addr kept", fail_addr, 32'h105);
    chk("R6", "first fail_exp kept", fail_exp, 8'h05);
    chk("R6", "first fail_act kept", fail_act, 8'h04);
    chk("R3", "request order over passes", seq_bad, 0);
  endtask

  task automatic t_sat();
    fmode = 3; seq_reset();
    pulse_start(4'd1);
    wait_done();
    chk("R5", "err_count saturates", err_count, 15);
    chk("R6", "fail_addr lowest", fail_addr, 5);
  endtask

  task automatic t_restart();
    fmode = 0; seq_reset();
    pulse_start(4'd1);
    chk("R8", "err_count cleared", err_count, 0);
    chk("R8", "fail_valid cleared", fail_valid, 0);
    chk("R8", "done cleared", done, 0);
    chk("R8", "pass_count cleared", pass_count, 0);
    wait_done();
    chk("R7", "restart run completes", pass_count, 1);
  endtask

  task automatic t_ignore_stall();
    fmode = 0; stall_en = 1; seq_reset();
    pulse_start(4'd2);
    repeat (200) @(negedge clk);
    pulse_start(4'd5);
    wait_done();
    stall_en = 0;
    chk("R2", "start while busy ignored", pass_count, 2);
    chk("R9", "err_count under stalls", err_count, 0);
    chk("R9", "request order under stalls", seq_bad, 0);
  endtask

  task automatic t_zero();
    fmode = 0; seq_reset();
    pulse_start(4'd0);
    wait_done();
    chk("R7", "zero means one sweep", pass_count, 1);
  endtask

  task automatic t_reset_mid();
    fmode = 1; f_a1 = 11'h002; f_m1 = 8'hFF;
    pulse_start(4'd2);
    repeat (2600) @(negedge clk);
    rst_n = 0;
    repeat (20) @(negedge clk);
    chk("R1", "busy after mid reset", busy, 0);
    chk("R1", "fail_valid after mid reset", fail_valid, 0);
    chk("R1", "err_count after mid reset", err_count, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0; sweep_cnt = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_clean();
    t_single();
    t_multi();
    t_sat();
    t_restart();
    t_ignore_stall();
    t_zero();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule